// File: doc/BRIEF.md
# Indirect Configuration Register Port

This block lets a host reach fourteen per-channel configuration registers through only two I/O locations. Offset 1 is a pointer. It selects a channel bank and a register index, and it also keeps a few bus-behaviour bits that software can read back. Offset 0 is a 16-bit data window onto whichever register the pointer selects. Software writes the pointer once. It then streams reads or writes through the window, and can let the index step forward by itself after each data access.

Each bank holds seven registers:

| Index | Contents | Width | Access |
|-------|----------|-------|--------|
| 0 | command-block base address | 16 bits | read/write |
| 1 | general configuration (DMA enable, I/O-port enable) | 8 bits | read/write |
| 2 | low 8 bits of a 10-bit read-ahead count | 8 bits | write-only |
| 3 | high 2 bits of the read-ahead count, plus a clear-FIFO command | 8 bits | write-only |
| 4 | control-block base address | 16 bits | read/write |
| 5 | data-port timing | 8 bits | read/write |
| 6 | command/control timing | 8 bits | read/write |

The host side is a plain synchronous strobe bus. Read data is registered.

Top module: `cfg_window_port`

## Requirements
- R1: After reset the pointer reads 0x0050. In each bank, index 1 reads 0x0001, index 5 reads 0x00F5 and index 6 reads 0x00DE. Index 0 reads 0x01F0 in bank 0 and 0x0170 in bank 1. Index 4 reads 0x03F6 in bank 0 and 0x0376 in bank 1.
- R2: A write to addr 1 stores wdata[7:0] into the pointer, and wdata[15:8] is ignored. A read of addr 1 returns the pointer zero-extended to 16 bits. Pointer bit 7 is auto-increment, bit 3 is the bank, bits 2..0 are the index, and bits 6..4 are stored only.
- R3: A write to addr 0 updates the register selected by the pointer. A read of addr 0 places that register on rdata on the clock edge that accepts rd_en. rdata keeps its value until the next read.
- R4: Indexes 0 and 4 store all 16 bits. Indexes 1, 5 and 6 store wdata[7:0], and their reads return 0 in bits 15..8.
- R5: Indexes 2 and 3 are write-only and read as 0x0000. ra_count[10*b+9:10*b] equals {index 3 bits 1..0, index 2 bits 7..0} of bank b.
- R6: A data write to index 3 with wdata[6]=1 raises fifo_clr[bank] for exactly the one cycle after the write. The bit is not stored.
- R7: When pointer bit 7 is 1, every data-port read or write advances the index by one, and index 6 (or 7) wraps to 0. The bank bit and bits 7..4 do not change. When bit 7 is 0, data accesses leave the pointer unchanged.
- R8: Index 7 holds no register. Writes to it change nothing, and reads of it return 0x0000.
- R9: Addresses 2 and 3 are unused. Writes to them change nothing, and reads of them return 0x0000.
- R10: dma_en[b] mirrors bit 7 and io_en[b] mirrors bit 0 of index 1 in bank b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | write strobe |
| rd_en | input | 1 | read strobe |
| addr | input | 2 | port offset (0 data, 1 pointer) |
| wdata | input | 16 | write data |
| rdata | output | 16 | registered read data |
| fifo_clr | output | 2 | one-cycle clear-FIFO pulse per bank |
| dma_en | output | 2 | DMA enable per bank |
| io_en | output | 2 | I/O-port enable per bank |
| ra_count | output | 20 | 10-bit read-ahead count per bank, bank 0 in the low bits |

## Verification
The bound checker watches the pointer on every cycle:
- Each data access must step the index and wrap it after 6 when auto-increment is on, and must leave the pointer still when it is off.
- fifo_clr must stay one-hot-or-zero and must only follow a data write.
- Reads of unused offsets and of write-only or empty indexes must return zero.
- rdata must hold between reads.

Only the bench scenarios can show that stored values survive and come back from the right bank and index. The same holds for the reset defaults, the 8-bit truncation, and the read-ahead count that is assembled across two writes.

// File: rtl/cfg_window_port.sv
module cfg_window_port #(
  parameter logic [15:0] CMD_RST0 = 16'h01F0,
  parameter logic [15:0] CMD_RST1 = 16'h0170,
  parameter logic [15:0] CTL_RST0 = 16'h03F6,
  parameter logic [15:0] CTL_RST1 = 16'h0376,
  parameter logic [7:0]  GEN_RST  = 8'h01,
  parameter logic [7:0]  DTM_RST  = 8'hF5,
  parameter logic [7:0]  CTM_RST  = 8'hDE,
  parameter logic [7:0]  PTR_RST  = 8'h50,
  parameter int          RA_W     = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [1:0]           addr,
  input  logic [15:0]          wdata,
  output logic [15:0]          rdata,
  output logic [1:0]           fifo_clr,
  output logic [1:0]           dma_en,
  output logic [1:0]           io_en,
  output logic [2*RA_W-1:0]    ra_count
);
  localparam int HI_W = RA_W - 8;
  localparam logic [2:0] LAST_IDX = 3'd6;

  logic [7:0] ptr;
  logic [1:0][15:0] cmd_base, ctl_base;
  logic [1:0][7:0]  gen_cfg, ra_lo, dtm, ctm;
  logic [1:0][HI_W-1:0] ra_hi;
  logic [15:0] rd_mux;

  wire       dat_sel = (addr == 2'd0);
  wire       ptr_sel = (addr == 2'd1);
  wire [2:0] idx     = ptr[2:0];
  wire       bank    = ptr[3];
  wire       dat_wr  = dat_sel && wr_en;
  wire       dat_acc = dat_sel && (wr_en || rd_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= PTR_RST;
    end else if (ptr_sel && wr_en) begin
      ptr <= wdata[7:0];
    end else if (dat_acc && ptr[7]) begin
      ptr[2:0] <= (idx >= LAST_IDX) ? 3'd0 : idx + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_base <= {CMD_RST1, CMD_RST0};
      ctl_base <= {CTL_RST1, CTL_RST0};
      gen_cfg  <= {2{GEN_RST}};
      dtm      <= {2{DTM_RST}};
      ctm      <= {2{CTM_RST}};
      ra_lo    <= '0;
      ra_hi    <= '0;
      fifo_clr <= '0;
    end else begin
      fifo_clr <= '0;
      if (dat_wr) begin
        case (idx)
          3'd0: cmd_base[bank] <= wdata;
          3'd1: gen_cfg[bank]  <= wdata[7:0];
          3'd2: ra_lo[bank]    <= wdata[7:0];
          3'd3: begin
            ra_hi[bank]    <= wdata[HI_W-1:0];
            fifo_clr[bank] <= wdata[6];
          end
          3'd4: ctl_base[bank] <= wdata;
          3'd5: dtm[bank]      <= wdata[7:0];
          3'd6: ctm[bank]      <= wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (ptr_sel) begin
      rd_mux = {8'h00, ptr};
    end else if (dat_sel) begin
      case (idx)
        3'd0: rd_mux = cmd_base[bank];
        3'd1: rd_mux = {8'h00, gen_cfg[bank]};
        3'd4: rd_mux = ctl_base[bank];
        3'd5: rd_mux = {8'h00, dtm[bank]};
        3'd6: rd_mux = {8'h00, ctm[bank]};
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  genvar b;
  generate
    for (b = 0; b < 2; b++) begin : g_bank
      assign dma_en[b] = gen_cfg[b][7];
      assign io_en[b]  = gen_cfg[b][0];
      assign ra_count[b*RA_W +: RA_W] = {ra_hi[b], ra_lo[b]};
    end
  endgenerate
endmodule

// File: rtl/cfg_window_port_chk.sv
module cfg_window_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [1:0]  addr,
  input logic [15:0] rdata,
  input logic [1:0]  fifo_clr,
  input logic [7:0]  ptr
);
  wire dacc = (rd_en || wr_en) && (addr == 2'd0);

  // R6
  fifo_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fifo_clr));

  // R6
  fifo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fifo_clr) |-> $past(wr_en && addr == 2'd0));

  // R7
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dacc && ptr[7]) |=> (ptr[2:0] == (($past(ptr[2:0]) >= 3'd6) ? 3'd0 : $past(ptr[2:0]) + 3'd1))
      && (ptr[7:3] == $past(ptr[7:3])));

  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dacc && !ptr[7]) |=> $stable(ptr));

  // R9
  gap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[1]) |=> (rdata == 16'h0000));

  // R5 and R8
  wo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0 && (ptr[2:0] == 3'd2 || ptr[2:0] == 3'd3 || ptr[2:0] == 3'd7))
      |=> (rdata == 16'h0000));

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind cfg_window_port cfg_window_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .fifo_clr(fifo_clr), .ptr(ptr)
);

// File: tb/cfg_window_port_tb.sv
module cfg_window_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  fifo_clr, dma_en, io_en;
  logic [19:0] ra_count;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  cfg_window_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .fifo_clr(fifo_clr), .dma_en(dma_en),
    .io_en(io_en), .ra_count(ra_count)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] e, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        total++; fails++;
        $display("FAIL R3 unexpected read actual=0x%0h expected=none", rdata);
      end else begin
        chk(tag_q.pop_front(), {16'h0, rdata}, {16'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 fifo_clr reset", {30'h0, fifo_clr}, 32'h0);
    chk("R1 R10 dma_en reset", {30'h0, dma_en}, 32'h0);
    chk("R1 R10 io_en reset", {30'h0, io_en}, 32'h3);
    chk("R1 ra_count reset", {12'h0, ra_count}, 32'h0);
    chk("R1 rdata reset", {16'h0, rdata}, 32'h0);
    rst_n = 1'b1;

    rd(2'd1, 16'h0050, "R1 R2 pointer default");
    rd(2'd0, 16'h01F0, "R1 b0 idx0");
    rd(2'd0, 16'h01F0, "R7 no advance");
    wr(2'd1, 16'h0004); rd(2'd0, 16'h03F6, "R1 b0 idx4");
    wr(2'd1, 16'h0005); rd(2'd0, 16'h00F5, "R1 b0 idx5");
    wr(2'd1, 16'h0006); rd(2'd0, 16'h00DE, "R1 b0 idx6");
    wr(2'd1, 16'h0001); rd(2'd0, 16'h0001, "R1 b0 idx1");
    wr(2'd1, 16'h0008); rd(2'd0, 16'h0170, "R1 b1 idx0");
    wr(2'd1, 16'h000C); rd(2'd0, 16'h0376, "R1 b1 idx4");
    wr(2'd1, 16'h000D); rd(2'd0, 16'h00F5, "R1 b1 idx5");
    wr(2'd1, 16'h000E); rd(2'd0, 16'h00DE, "R1 b1 idx6");

    wr(2'd1, 16'h00D5);
    rd(2'd0, 16'h00F5, "R7 autoinc read idx5");
    rd(2'd0, 16'h00DE, "R7 autoinc read idx6");
    rd(2'd0, 16'h01F0, "R7 wrap to idx0");
    rd(2'd1, 16'h00D1, "R7 pointer after reads");

    wr(2'd0, 16'h0081);
    wr(2'd0, 16'h00AA);
    wr(2'd0, 16'h0042);
    chk("R6 fifo_clr bank0 pulse", {30'h0, fifo_clr}, 32'h1);
    @(negedge clk);
    chk("R6 fifo_clr one cycle", {30'h0, fifo_clr}, 32'h0);
    chk("R10 dma_en bank0", {30'h0, dma_en}, 32'h1);
    chk("R10 io_en", {30'h0, io_en}, 32'h3);
    chk("R5 ra_count bank0", {22'h0, ra_count[9:0]}, 32'h2AA);
    rd(2'd1, 16'h00D4, "R7 pointer after writes");

    wr(2'd1, 16'h0001); rd(2'd0, 16'h0081, "R3 idx1 readback");
    wr(2'd1, 16'h0002); rd(2'd0, 16'h0000, "R5 idx2 reads zero");
    wr(2'd1, 16'h0003); rd(2'd0, 16'h0000, "R5 R6 idx3 reads zero");

    wr(2'd1, 16'h000B); wr(2'd0, 16'h00C3);
    chk("R6 fifo_clr bank1 pulse", {30'h0, fifo_clr}, 32'h2);
    wr(2'd1, 16'h000A); wr(2'd0, 16'h00AB);
    chk("R5 ra_count bank1", {22'h0, ra_count[19:10]}, 32'h3AB);
    chk("R5 ra_count bank0 kept", {22'h0, ra_count[9:0]}, 32'h2AA);
    rd(2'd0, 16'h0000, "R5 b1 idx2 reads zero");

    wr(2'd1, 16'h0004); wr(2'd0, 16'hABCD); rd(2'd0, 16'hABCD, "R4 idx4 16 bits");
    wr(2'd1, 16'h0005); wr(2'd0, 16'h1234); rd(2'd0, 16'h0034, "R4 idx5 8 bits");

    wr(2'd1, 16'h0007); wr(2'd0, 16'hFFFF); rd(2'd0, 16'h0000, "R8 idx7 reads zero");
    wr(2'd1, 16'h0006); rd(2'd0, 16'h00DE, "R8 idx6 untouched");
    wr(2'd1, 16'h0000); rd(2'd0, 16'h01F0, "R8 idx0 untouched");

    rd(2'd2, 16'h0000, "R9 addr2 reads zero");
    rd(2'd3, 16'h0000, "R9 addr3 reads zero");
    wr(2'd2, 16'hFFFF); wr(2'd3, 16'hFFFF);
    rd(2'd1, 16'h0000, "R9 pointer untouched");
    rd(2'd0, 16'h01F0, "R9 data untouched");
    chk("R9 dma_en untouched", {30'h0, dma_en}, 32'h1);

    wr(2'd1, 16'hFF8F);
    rd(2'd1, 16'h008F, "R2 upper wdata ignored");
    rd(2'd0, 16'h0000, "R7 R8 autoinc idx7 read");
    rd(2'd0, 16'h0170, "R7 wrap from idx7 in bank1");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; fails++;
      $display("FAIL R3 reads pending actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule